// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product of two operands with one 16-bit multiply-accumulate datapath. For a modulus N of K bits (K a multiple of 16), the radix is R = 2^(K+16), one word wider than the modulus. Software or a sequencer first writes the operands A and B, the modulus N and the precomputed coefficient C = −N⁻¹ mod R into four small word-addressed banks. It then pulses `start` and waits for `done`. The result is then read word by word from a local result bank.

The operation runs as three word-serial passes over a scratch accumulator. The product pass forms T = A·B. The reduction-multiple pass forms m = (T mod R)·C mod R, keeping only the low K+16 bits. The accumulate pass forms T + m·N. After that pass the low K+16 bits are zero, so the result is the upper half of the accumulator, taken with a plain word shift. Because the reduction spans K+16 bits rather than K, operands anywhere in [0, 2N) give a result below 2N. No trailing subtraction of N is needed, and results can be fed back in as operands unchanged.

The controller has seven states:

| State | Action |
|-------|--------|
| IDLE | Waits. |
| CLEAR | Zeroes the accumulator and m. |
| PROD | Runs the product pass. |
| REDM | Runs the reduction-multiple pass. |
| ACCUM | Runs the accumulate pass. |
| COPY | Moves the upper accumulator words to the result bank. |
| DONE | Raises `done`. |

Its transitions are:

| Transition | Condition |
|------------|-----------|
| IDLE→CLEAR | `start` is sampled high. |
| CLEAR→PROD | Always, after one cycle. |
| PROD→REDM, REDM→ACCUM, ACCUM→COPY | The last word step of the last row of the pass. |
| COPY→DONE | The last result word has been written. |
| DONE→IDLE | Always, after one cycle. |

Top module: `mont_mul_ws`

## Requirements
- R1: The result S satisfies S ≡ A·B·2^−(K+16) (mod N) for odd N and A, B in [0, 2N).
- R2: The result S is less than 2N with no final subtraction. The top result word (index K/16) is therefore 0 or 1.
- R3: The result equals exactly (T + m·N) >> (K+16), where T = A·B and m = ((T mod 2^(K+16))·C) mod 2^(K+16). The low K+16 bits of T + m·N are all zero.
- R4: Bank word layout. Every bank holds W = K/16+1 words of 16 bits, least significant word at address 0. The `ld_sel` codes are: 0 selects A, 1 selects B, 2 selects N, 3 selects C. A, B and C use all W words, and the result bank also has W words.
- R5: `done` is high for exactly one cycle. It rises L clock edges after the edge that samples `start`, where L = 1 + W(W+1) + W(W+1)/2 + (3W²+W)/2 + W. This is 37 for W = 3.
- R6: A `start` pulse while `busy` is high is ignored. It neither restarts nor extends the running operation, and no second `done` follows.
- R7: After reset, `busy` and `done` are low and every bank reads zero.
- R8: The accumulate pass never carries out of the top accumulator word.
- R9: The N bank word at address K/16 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when sampled high in IDLE |
| ld_en | input | 1 | Writes `ld_data` into the selected bank |
| ld_sel | input | 2 | Bank select: 0 = A, 1 = B, 2 = N, 3 = C |
| ld_addr | input | clog2(W) | Word address within the bank |
| ld_data | input | 16 | Word to write |
| res_addr | input | clog2(W) | Result bank read address |
| res_data | output | 16 | Result word at `res_addr` (combinational read) |
| busy | output | 1 | High from CLEAR through DONE |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with K = 32, so W = 3 words and R = 2^48. With these values every intermediate quantity fits in the bench's native wide arithmetic, and the congruence can be computed independently by halving modulo N 48 times. The bench sweeps eight moduli: the smallest odd modulus, the all-ones modulus, sparse and dense bit patterns, and random odd values. Each modulus is crossed with operands at 0, 1, N−1, N, 2N−1 and random points below 2N. This reaches the extreme corners of the 2N bound and the carry chains through every word.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int WORD_W = 16;
    localparam int NUM_BANKS = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_PROD  = 3'd2,
        ST_REDM  = 3'd3,
        ST_ACCUM = 3'd4,
        ST_COPY  = 3'd5,
        ST_DONE  = 3'd6
    } mm_state_e;

    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_N = 2'd2,
        BANK_C = 2'd3
    } bank_sel_e;
endpackage

// File: rtl/mm_regfile.sv
module mm_regfile
    import mm_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NRD   = 1,
    parameter int AW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  word_t                 wdata,
    input  logic [NRD*AW-1:0]     raddr,
    output logic [NRD*WORD_W-1:0] rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = raddr[p*AW +: AW];
        assign rdata[p*WORD_W +: WORD_W] = (int'(ra) < DEPTH) ? mem[ra] : '0;
    end
endmodule

// File: rtl/mm_mac.sv
module mm_mac
    import mm_pkg::*;
(
    input  word_t                 x,
    input  word_t                 y,
    input  word_t                 acc,
    input  word_t                 cin,
    output logic [2*WORD_W-1:0]   sum
);
    // (2^16-1)^2 + 2*(2^16-1) = 2^32-1: never overflows 32 bits
    always_comb begin
        sum = (32'(x) * 32'(y)) + 32'(acc) + 32'(cin);
    end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int RW = 3,
    parameter int IW = 2,
    parameter int JW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output mm_state_e       state,
    output logic [IW-1:0]   row,
    output logic [JW-1:0]   col,
    output logic            row_end,
    output logic            busy,
    output logic            done
);
    mm_state_e     state_nx;
    logic [JW-1:0] col_last;
    logic          last_row;

    // last column of the current row, per pass
    always_comb begin
        unique case (state)
            ST_PROD:  col_last = JW'(RW);
            ST_REDM:  col_last = JW'(RW - 1) - JW'(row);
            ST_ACCUM: col_last = JW'(2 * RW - 1) - JW'(row);
            default:  col_last = JW'(RW - 1);
        endcase
        row_end  = (col == col_last);
        last_row = (row == IW'(RW - 1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CLEAR;
            ST_CLEAR: state_nx = ST_PROD;
            ST_PROD:  if (row_end && last_row) state_nx = ST_REDM;
            ST_REDM:  if (row_end && last_row) state_nx = ST_ACCUM;
            ST_ACCUM: if (row_end && last_row) state_nx = ST_COPY;
            ST_COPY:  if (row_end) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else begin
            unique case (state)
                ST_PROD, ST_REDM, ST_ACCUM, ST_COPY: begin
                    if (row_end) begin
                        col <= '0;
                        row <= (last_row || state == ST_COPY) ? '0 : row + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                default: begin
                    row <= '0;
                    col <= '0;
                end
            endcase
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a start seen while busy never re-enters the clear state
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state != ST_CLEAR));
endmodule

// File: rtl/mont_mul_ws.sv
module mont_mul_ws
    import mm_pkg::*;
#(
    parameter int K_BITS = 256
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start,
    input  logic                                         ld_en,
    input  logic [1:0]                                   ld_sel,
    input  logic [$clog2(K_BITS/16+1)-1:0]               ld_addr,
    input  logic [15:0]                                  ld_data,
    input  logic [$clog2(K_BITS/16+1)-1:0]               res_addr,
    output logic [15:0]                                  res_data,
    output logic                                         busy,
    output logic                                         done
);
    localparam int NW     = K_BITS / WORD_W;
    localparam int RW     = NW + 1;
    localparam int AW     = $clog2(RW);
    localparam int TDEPTH = 2 * RW;
    localparam int TW     = $clog2(TDEPTH);
    localparam int IW     = $clog2(RW);
    localparam int JW     = $clog2(TDEPTH) + 1;

    mm_state_e     state;
    logic [IW-1:0] row;
    logic [JW-1:0] col;
    logic          row_end;

    mm_ctrl #(.RW(RW), .IW(IW), .JW(JW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state   (state),
        .row     (row),
        .col     (col),
        .row_end (row_end),
        .busy    (busy),
        .done    (done)
    );

    // ---------------- operand banks ----------------
    logic [JW-1:0] y_len;
    logic          y_in_range;
    logic [AW-1:0] y_addr;
    word_t         bank_q  [NUM_BANKS];
    logic [AW-1:0] bank_ra [NUM_BANKS];

    always_comb begin
        y_len      = (state == ST_ACCUM) ? JW'(NW) : JW'(RW);
        y_in_range = (col < y_len);
        y_addr     = y_in_range ? AW'(col) : '0;
    end

    assign bank_ra[BANK_A] = AW'(row);
    assign bank_ra[BANK_B] = y_addr;
    assign bank_ra[BANK_N] = y_addr;
    assign bank_ra[BANK_C] = y_addr;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        mm_regfile #(.DEPTH(RW), .NRD(1), .AW(AW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (1'b0),
            .we    (ld_en && (ld_sel == 2'(g))),
            .waddr (ld_addr),
            .wdata (ld_data),
            .raddr (bank_ra[g]),
            .rdata (bank_q[g])
        );
    end

    // ---------------- scratch: accumulator T and multiple m ----------------
    logic [JW-1:0] tgt_idx;
    logic [TW-1:0] t_ra1;
    word_t         t_rd0, t_rd1, m_rd0, m_rd1;
    logic [2*WORD_W-1:0] sum;
    word_t         carry;
    word_t         x_w, y_w, acc_w;
    logic          t_we, m_we, res_we;

    assign tgt_idx = JW'(row) + col;

    always_comb begin
        unique case (state)
            ST_REDM: t_ra1 = TW'(row);
            ST_COPY: t_ra1 = TW'(RW) + TW'(col);
            default: t_ra1 = '0;
        endcase
    end

    mm_regfile #(.DEPTH(TDEPTH), .NRD(2), .AW(TW)) u_tacc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_CLEAR),
        .we    (t_we),
        .waddr (TW'(tgt_idx)),
        .wdata (sum[WORD_W-1:0]),
        .raddr ({t_ra1, TW'(tgt_idx)}),
        .rdata ({t_rd1, t_rd0})
    );

    mm_regfile #(.DEPTH(RW), .NRD(2), .AW(AW)) u_mbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_CLEAR),
        .we    (m_we),
        .waddr (AW'(tgt_idx)),
        .wdata (sum[WORD_W-1:0]),
        .raddr ({AW'(row), AW'(tgt_idx)}),
        .rdata ({m_rd1, m_rd0})
    );

    // ---------------- operand selection per pass ----------------
    always_comb begin
        x_w   = '0;
        y_w   = '0;
        acc_w = '0;
        unique case (state)
            ST_PROD: begin
                x_w   = bank_q[BANK_A];
                y_w   = y_in_range ? bank_q[BANK_B] : '0;
                acc_w = t_rd0;
            end
            ST_REDM: begin
                x_w   = t_rd1;
                y_w   = y_in_range ? bank_q[BANK_C] : '0;
                acc_w = m_rd0;
            end
            ST_ACCUM: begin
                x_w   = m_rd1;
                y_w   = y_in_range ? bank_q[BANK_N] : '0;
                acc_w = t_rd0;
            end
            default: ;
        endcase
    end

    mm_mac u_mac (
        .x   (x_w),
        .y   (y_w),
        .acc (acc_w),
        .cin (carry),
        .sum (sum)
    );

    always_comb begin
        t_we   = (state == ST_PROD) || (state == ST_ACCUM);
        m_we   = (state == ST_REDM);
        res_we = (state == ST_COPY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry <= '0;
        end else if ((state == ST_PROD || state == ST_REDM || state == ST_ACCUM) && !row_end) begin
            carry <= sum[2*WORD_W-1:WORD_W];
        end else begin
            carry <= '0;
        end
    end

    // ---------------- result bank ----------------
    mm_regfile #(.DEPTH(RW), .NRD(1), .AW(AW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .we    (res_we),
        .waddr (AW'(col)),
        .wdata (t_rd1),
        .raddr (res_addr),
        .rdata (res_data)
    );

    // R3: word finalised by each accumulate row must be zero
    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && col == '0) |-> (sum[WORD_W-1:0] == '0));

    // R8: no carry leaves the top word of the accumulator
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && row_end) |-> (sum[2*WORD_W-1:WORD_W] == '0));

    // R2: top result word below 2 because the result is under 2N
    p_result_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY && row_end) |-> (t_rd1 <= 16'd1));

    // R4: result writes stay inside the result bank
    p_copy_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY) |-> (int'(col) < RW));
endmodule

// File: tb/mont_mul_ws_bench.sv
module mont_mul_ws_bench;
    localparam int K  = 32;
    localparam int NW = K / 16;
    localparam int RW = NW + 1;
    localparam int AW = $clog2(RW);
    localparam int LAT = 1 + RW*(RW+1) + RW*(RW+1)/2 + (3*RW*RW + RW)/2 + RW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ld_en = 1'b0;
    logic [1:0] ld_sel = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [AW-1:0] res_addr = '0;
    logic [15:0] res_data;
    logic busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mont_mul_ws #(.K_BITS(K)) u_mont_mul_ws (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
        .res_addr(res_addr), .res_data(res_data), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [47:0] neg_inv(input logic [31:0] n);
        logic [63:0] inv;
        inv = 64'(n);
        for (int k = 0; k < 6; k++) inv = inv * (64'd2 - 64'(n) * inv);
        return 48'(~inv + 64'd1);
    endfunction

    // independent congruence: a*b*2^-48 mod n by repeated halving
    function automatic logic [63:0] model_mod(input logic [47:0] a, input logic [47:0] b, input logic [31:0] n);
        logic [63:0] x;
        x = ((64'(a) % 64'(n)) * (64'(b) % 64'(n))) % 64'(n);
        for (int k = 0; k < 48; k++) x = x[0] ? (x + 64'(n)) >> 1 : x >> 1;
        return x;
    endfunction

    function automatic logic [47:0] model_exact(input logic [47:0] a, input logic [47:0] b,
                                                input logic [31:0] n, input logic [47:0] c);
        logic [127:0] t, m, u;
        t = 128'(a) * 128'(b);
        m = (128'(t[47:0]) * 128'(c)) & ((128'd1 << 48) - 128'd1);
        u = t + m * 128'(n);
        return 48'(u >> 48);
    endfunction

    task automatic load(input logic [1:0] sel, input int addr, input logic [15:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = AW'(addr); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic read_res(output logic [47:0] r);
        for (int k = 0; k < RW; k++) begin
            res_addr = AW'(k);
            #1;
            r[16*k +: 16] = res_data;
        end
    endtask

    task automatic run_op(input logic [47:0] a, input logic [47:0] b, input logic [31:0] n,
                          input logic [15:0] junk, input bit poke, output logic [47:0] r, output int lat);
        logic [47:0] c;
        int dn;
        c = neg_inv(n);
        for (int k = 0; k < RW; k++) begin
            load(2'd0, k, a[16*k +: 16]);
            load(2'd1, k, b[16*k +: 16]);
            load(2'd3, k, c[16*k +: 16]);
        end
        load(2'd2, 0, n[15:0]);
        load(2'd2, 1, n[31:16]);
        load(2'd2, NW, junk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        dn = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 6) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R5 done width", 64'(done), 64'd0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 0 && busy == 1'b0, "R6 no second run", 64'(dn), 64'd0);
        read_res(r);
    endtask

    task automatic check_op(input logic [47:0] a, input logic [47:0] b, input logic [31:0] n,
                            input logic [15:0] junk, input bit poke);
        logic [47:0] r, ex;
        int lat;
        run_op(a, b, n, junk, poke, r, lat);
        ex = model_exact(a, b, n, neg_inv(n));
        chk(lat == LAT + 1, "R5 latency", 64'(lat), 64'(LAT + 1));
        chk(r == ex, "R3 R4 R9 exact result", 64'(r), 64'(ex));
        chk(64'(r) < 64'(n) * 64'd2, "R2 bound", 64'(r), 64'(n) * 64'd2);
        chk(64'(r) % 64'(n) == model_mod(a, b, n), "R1 congruence",
            64'(r) % 64'(n), model_mod(a, b, n));
    endtask

    initial begin
        logic [31:0] nlist [8];
        logic [47:0] ops [6];
        logic [47:0] r0, r1;
        int lat;
        nlist[0] = 32'd3;
        nlist[1] = 32'hFFFF_FFFF;
        nlist[2] = 32'h8000_0001;
        nlist[3] = 32'hFFFF_0001;
        nlist[4] = 32'h0001_0001;
        nlist[5] = 32'h0000_FFFF;
        nlist[6] = $urandom | 32'h1;
        nlist[7] = $urandom | 32'h8000_0001;

        repeat (3) @(negedge clk);
        // R7: reset state
        chk(busy == 1'b0, "R7 busy at reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R7 done at reset", 64'(done), 64'd0);
        read_res(r0);
        chk(r0 == '0, "R7 result bank at reset", 64'(r0), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R7 idle after reset", 64'(busy), 64'd0);

        foreach (nlist[q]) begin
            logic [31:0] n;
            n = nlist[q];
            ops[0] = 48'd0;
            ops[1] = 48'd1;
            ops[2] = 48'(n) - 48'd1;
            ops[3] = 48'(n);
            ops[4] = 48'(n) * 48'd2 - 48'd1;
            ops[5] = 48'({$urandom, $urandom} % (64'(n) * 64'd2));
            foreach (ops[p]) begin
                foreach (ops[s]) begin
                    check_op(ops[p], ops[s], n, 16'($urandom), 1'b0);
                end
            end
        end

        // R6: start pulse mid-run is ignored
        check_op(48'h1_2345_6789, 48'h0_9876_5432, 32'hFFFF_FFFB, 16'h0, 1'b1);

        // R9: top word of N bank has no effect
        run_op(48'h1_1111_2222, 48'h0_3333_4444, 32'hF00D_0005, 16'h0000, 1'b0, r0, lat);
        run_op(48'h1_1111_2222, 48'h0_3333_4444, 32'hF00D_0005, 16'hFFFF, 1'b0, r1, lat);
        chk(r0 == r1, "R9 N top word ignored", 64'(r1), 64'(r0));

        // R1 R2: result fed back as operand stays consistent
        check_op(r0, r0, 32'hF00D_0005, 16'h1234, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule